// File: doc/BRIEF.md
# Eight-Phase Memory Cycle Timing Sequencer

This block produces the repeating phase frame that paces one memory access in a small word-oriented processor. A free-running clock drives the logic, and a separate enable input marks each base phase tick. On each tick the sequencer moves a one-hot phase vector forward by one position, from T0 through to the final phase T7. It then wraps back to T0 and raises a one-clock cycle-start strobe that marks the start of the next memory cycle.

The final phase can be stretched in two ways. An arithmetic-busy input or a general hold input, such as a cycle-steal request, keeps the sequencer in T7. The condition is tested again on every tick. A build-time extension count adds a fixed number of extra T7 ticks to every cycle, which slows the machine to the timing of a cheaper, deliberately throttled model. With an extension count of zero the block runs at full speed, and every cycle lasts exactly as many ticks as there are phases.

Top module: `phase_seq`

## Requirements
- R1: `phase_oh` has exactly one bit set at all times after reset. Bit k stands for phase Tk, and synchronous reset puts the sequencer in T0 (`phase_oh` = 1) with `cycle_start` low.
- R2: A clock edge on which `tick_en` is low changes neither `phase_oh` nor the extension count, and leaves `cycle_start` low.
- R3: On each enabled tick in phases T0 to T6 (after the start-up tick of R8), the set bit moves up by exactly one position. `arith_busy` and `hold_req` have no effect in those phases.
- R4: On an enabled tick in T7 with `arith_busy` or `hold_req` high, the sequencer stays in T7. The two inputs have equal weight and are tested again on every tick.
- R5: On an enabled tick in T7 with both hold inputs low and the extension count used up, the sequencer moves to T0 and `cycle_start` is high for the following clock.
- R6: The extension counter is loaded with `EXT_TICKS` on the tick that enters T7. Each T7 tick that does not wrap lowers it by one, whether or not a hold is active. With no holds, T7 therefore lasts `EXT_TICKS`+1 ticks.
- R7: With `EXT_TICKS` = 0 and no holds, one full cycle takes exactly `PHASES` ticks.
- R8: After reset, the first enabled tick leaves the phase at T0 and raises `cycle_start` for one clock. The next tick moves to T1.
- R9: `cycle_start` is high for a single clock, and only while `phase_oh` shows T0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Base phase tick enable, one clock wide |
| arith_busy | input | 1 | Arithmetic still in progress; holds T7 |
| hold_req | input | 1 | General hold request (e.g. cycle steal); holds T7 |
| phase_oh | output | PHASES | One-hot phase vector, bit k = Tk |
| cycle_start | output | 1 | One-clock strobe when a new cycle begins at T0 |

## Verification
The hardest case to reach is the overlap of a busy or hold condition with the extension countdown in the slowed build. The T7 dwell must equal the longer of the two, so the bench has to line up a hold run against the counter. It does this by running a full-speed instance and an instance with three extension ticks in lockstep on the same tick and hold stimulus. Holds of one tick and of five ticks are applied across several cycles, so that a hold ends both before and after the extension count is used up. A reset in the middle of a cycle and ticks separated by idle clocks cover the start-up and gating paths.

// File: rtl/phase_seq_pkg.sv
package phase_seq_pkg;

  // Width of a down-counter that must hold values 0..max_val.
  function automatic int unsigned cnt_width(input int unsigned max_val);
    int unsigned w;
    w = 1;
    while ((1 << w) <= max_val) w++;
    return w;
  endfunction

endpackage

// File: rtl/phase_ring.sv
module phase_ring #(
  parameter int unsigned PHASES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  output logic [PHASES-1:0] phase_oh
);

  localparam logic [PHASES-1:0] RESET_VAL = {{(PHASES-1){1'b0}}, 1'b1};

  // Rotating one-hot ring: the top bit wraps back to bit 0.
  always_ff @(posedge clk) begin
    if (rst) begin
      phase_oh <= RESET_VAL;
    end else if (step) begin
      phase_oh <= {phase_oh[PHASES-2:0], phase_oh[PHASES-1]};
    end
  end

endmodule

// File: rtl/ext_counter.sv
module ext_counter
  import phase_seq_pkg::*;
#(
  parameter int unsigned EXT_TICKS = 0
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic dec,
  output logic done
);

  generate
    if (EXT_TICKS == 0) begin : g_full_speed
      logic unused_inputs;
      assign unused_inputs = ^{clk, rst, load, dec};
      assign done = 1'b1;
    end else begin : g_slowed
      localparam int unsigned CW = cnt_width(EXT_TICKS);
      localparam logic [CW-1:0] LOAD_VAL = CW'(EXT_TICKS);

      logic [CW-1:0] cnt;

      always_ff @(posedge clk) begin
        if (rst) begin
          cnt <= '0;
        end else if (load) begin
          cnt <= LOAD_VAL;
        end else if (dec && (cnt != '0)) begin
          cnt <= cnt - 1'b1;
        end
      end

      assign done = (cnt == '0);
    end
  endgenerate

endmodule

// File: rtl/phase_wrap_gate.sv
module phase_wrap_gate (
  input  logic at_last,
  input  logic ext_done,
  input  logic arith_busy,
  input  logic hold_req,
  output logic wrap_ok,
  output logic dwell
);

  logic held;

  always_comb begin
    held    = arith_busy | hold_req;
    wrap_ok = at_last & ext_done & ~held;
    dwell   = at_last & ~wrap_ok;
  end

endmodule

// File: rtl/phase_seq.sv
module phase_seq #(
  parameter int unsigned PHASES    = 8,
  parameter int unsigned EXT_TICKS = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              arith_busy,
  input  logic              hold_req,
  output logic [PHASES-1:0] phase_oh,
  output logic              cycle_start
);

  logic at_last;
  logic pre_last;
  logic ext_done;
  logic wrap_ok;
  logic dwell;
  logic step;
  logic start_pend;

  assign at_last  = phase_oh[PHASES-1];
  assign pre_last = phase_oh[PHASES-2];

  phase_wrap_gate u_gate (
    .at_last    (at_last),
    .ext_done   (ext_done),
    .arith_busy (arith_busy),
    .hold_req   (hold_req),
    .wrap_ok    (wrap_ok),
    .dwell      (dwell)
  );

  // Advance on a tick unless the first tick after reset is being consumed
  // or the final phase is dwelling.
  assign step = tick_en & ~start_pend & ~dwell;

  phase_ring #(.PHASES(PHASES)) u_ring (
    .clk      (clk),
    .rst      (rst),
    .step     (step),
    .phase_oh (phase_oh)
  );

  ext_counter #(.EXT_TICKS(EXT_TICKS)) u_ext (
    .clk  (clk),
    .rst  (rst),
    .load (step & pre_last),
    .dec  (tick_en & dwell),
    .done (ext_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      start_pend  <= 1'b1;
      cycle_start <= 1'b0;
    end else begin
      if (tick_en) start_pend <= 1'b0;
      cycle_start <= tick_en & (start_pend | wrap_ok);
    end
  end

endmodule

// File: rtl/phase_seq_chk.sv
module phase_seq_chk #(
  parameter int unsigned PHASES = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              tick_en,
  input logic              arith_busy,
  input logic              hold_req,
  input logic [PHASES-1:0] phase_oh,
  input logic              cycle_start,
  input logic              start_pend
);

  // R1: exactly one phase active
  a_r1_onehot: assert property (@(posedge clk) disable iff (rst)
    $countones(phase_oh) == 1);

  // R2: no tick, no phase change and no strobe
  a_r2_idle_stable: assert property (@(posedge clk) disable iff (rst)
    !tick_en |=> ($stable(phase_oh) && !cycle_start));

  // R3: ordinary phases step up by one
  a_r3_step_up: assert property (@(posedge clk) disable iff (rst)
    (tick_en && !start_pend && !phase_oh[PHASES-1])
      |=> (phase_oh == ($past(phase_oh) << 1)));

  // R4: busy or hold keeps the final phase
  a_r4_hold_last: assert property (@(posedge clk) disable iff (rst)
    (tick_en && phase_oh[PHASES-1] && (arith_busy || hold_req))
      |=> phase_oh[PHASES-1]);

  // R9: strobe only in T0 and only one clock long
  a_r9_strobe_t0: assert property (@(posedge clk) disable iff (rst)
    cycle_start |-> phase_oh[0]);

  a_r9_strobe_single: assert property (@(posedge clk) disable iff (rst)
    cycle_start |=> !cycle_start);

  // R8: first tick after reset keeps T0 and starts a cycle
  a_r8_first_tick: assert property (@(posedge clk) disable iff (rst)
    (tick_en && start_pend) |=> (phase_oh[0] && cycle_start));

endmodule

bind phase_seq phase_seq_chk #(.PHASES(PHASES)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .tick_en     (tick_en),
  .arith_busy  (arith_busy),
  .hold_req    (hold_req),
  .phase_oh    (phase_oh),
  .cycle_start (cycle_start),
  .start_pend  (start_pend)
);

// File: tb/phase_seq_tb.sv
`timescale 1ns/1ps
module phase_seq_tb;

  localparam int PH       = 8;
  localparam int EXT_SLOW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_en = 1'b0;
  logic arith_busy = 1'b0;
  logic hold_req = 1'b0;
  logic [PH-1:0] ph_f, ph_s;
  logic cs_f, cs_s;

  always #2.5 clk = ~clk;

  phase_seq #(.PHASES(PH), .EXT_TICKS(0)) u_dut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .arith_busy(arith_busy),
    .hold_req(hold_req), .phase_oh(ph_f), .cycle_start(cs_f));

  phase_seq #(.PHASES(PH), .EXT_TICKS(EXT_SLOW)) u_dut_slow (
    .clk(clk), .rst(rst), .tick_en(tick_en), .arith_busy(arith_busy),
    .hold_req(hold_req), .phase_oh(ph_s), .cycle_start(cs_s));

  typedef struct {
    logic [PH-1:0] ef, es;
    logic          cf, cs;
    string         tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Reference models: index 0 full speed, 1 slowed
  int  m_ph[2];
  int  m_cnt[2];
  bit  m_pend[2];
  bit  m_cs[2];
  int  m_ext[2];

  task automatic model_reset();
    for (int i = 0; i < 2; i++) begin
      m_ph[i] = 0; m_cnt[i] = 0; m_pend[i] = 1'b1; m_cs[i] = 1'b0;
    end
  endtask

  task automatic model_edge(input bit tk, input bit b, input bit h);
    for (int i = 0; i < 2; i++) begin
      m_cs[i] = 1'b0;
      if (tk) begin
        if (m_pend[i]) begin
          m_pend[i] = 1'b0; m_cs[i] = 1'b1;
        end else if (m_ph[i] == PH-1) begin
          if (m_cnt[i] == 0 && !b && !h) begin
            m_ph[i] = 0; m_cs[i] = 1'b1;
          end else if (m_cnt[i] > 0) begin
            m_cnt[i]--;
          end
        end else begin
          m_ph[i]++;
          if (m_ph[i] == PH-1) m_cnt[i] = m_ext[i];
        end
      end
    end
  endtask

  task automatic push(input string tag);
    exp_t e;
    e.ef = PH'(1) << m_ph[0];
    e.es = PH'(1) << m_ph[1];
    e.cf = m_cs[0];
    e.cs = m_cs[1];
    e.tag = tag;
    q.push_back(e);
  endtask

  // Driver: one clock of stimulus, expected result queued after the edge
  task automatic drive(input bit tk, input bit b, input bit h, input string tag);
    @(negedge clk);
    tick_en = tk; arith_busy = b; hold_req = h;
    @(posedge clk);
    model_edge(tk, b, h);
    #1 push(tag);
  endtask

  task automatic ticks(input int n, input bit b, input bit h, input string tag);
    for (int i = 0; i < n; i++) drive(1'b1, b, h, tag);
  endtask

  task automatic apply_reset(input string tag);
    @(negedge clk);
    rst = 1'b1; tick_en = 1'b0; arith_busy = 1'b0; hold_req = 1'b0;
    @(posedge clk);
    model_reset();
    #1 push(tag);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // Monitor: compare queued expectations away from the active edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (ph_f !== e.ef || cs_f !== e.cf) begin
        errors++;
        $display("FAIL %s full-speed: phase=%b cs=%b expected phase=%b cs=%b",
                 e.tag, ph_f, cs_f, e.ef, e.cf);
      end
      checks++;
      if (ph_s !== e.es || cs_s !== e.cs) begin
        errors++;
        $display("FAIL %s slowed: phase=%b cs=%b expected phase=%b cs=%b",
                 e.tag, ph_s, cs_s, e.es, e.cs);
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    m_ext[0] = 0;
    m_ext[1] = EXT_SLOW;
    model_reset();
    repeat (3) @(posedge clk);
    apply_reset("R1 reset state");
    // R2: idle clocks leave T0 untouched
    for (int i = 0; i < 3; i++) drive(1'b0, 1'b1, 1'b1, "R2 idle after reset");
    // R8: first tick keeps T0 and strobes
    ticks(1, 1'b0, 1'b0, "R8 first tick");
    ticks(1, 1'b0, 1'b0, "R8 second tick to T1");
    // R3 / R7 / R5 / R6: free-running cycles, slowed instance dwells
    ticks(2 * (PH + EXT_SLOW), 1'b0, 1'b0, "R3 R5 R6 R7 free run");
    // R2: ticks separated by idle clocks
    for (int i = 0; i < 10; i++) begin
      drive(1'b1, 1'b0, 1'b0, "R3 spaced tick");
      drive(1'b0, 1'b0, 1'b0, "R2 gap");
      drive(1'b0, 1'b0, 1'b0, "R2 gap");
    end
    // R4: arith busy held across whole cycles
    ticks(3 * PH, 1'b1, 1'b0, "R4 busy held");
    ticks(PH + EXT_SLOW, 1'b0, 1'b0, "R5 release after busy");
    // R4: hold request, same effect
    ticks(2 * PH, 1'b0, 1'b1, "R4 hold request");
    ticks(PH + EXT_SLOW, 1'b0, 1'b0, "R5 release after hold");
    // R6: short and long holds against the extension countdown
    for (int c = 0; c < 4; c++) begin
      ticks(PH - 1, 1'b0, 1'b0, "R6 approach last");
      ticks(1 + 4 * (c % 2), c[1], ~c[1], "R6 hold vs extension");
      ticks(EXT_SLOW + 2, 1'b0, 1'b0, "R6 drain");
    end
    // R8: reset in mid cycle, then restart
    ticks(3, 1'b0, 1'b0, "R3 pre reset");
    apply_reset("R1 mid-cycle reset");
    drive(1'b0, 1'b0, 1'b0, "R2 idle after reset");
    ticks(1, 1'b1, 1'b1, "R8 first tick ignores holds");
    ticks(2 * (PH + EXT_SLOW), 1'b0, 1'b0, "R9 strobe per cycle");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule